// File: doc/BRIEF.md
# Codec control-port register slave

This block is the write-only configuration port of an audio codec. A host sends 16-bit commands to it over a serial link. Each command carries a 7-bit register address in its upper bits and a 9-bit value in its lower bits. The block decodes the command and updates a bank of 9-bit configuration registers. All registers are presented in parallel on one flat output bus for the codec datapath.

A static strap input selects the link protocol. With the strap low, the link is three-wire: a chip select, a serial clock and a data line. With the strap high, the link is two-wire: start and stop conditions, a device address byte and an acknowledge that the block drives low.

The bank comes out of reset with fixed defaults. A special command returns every register to its default. The two line-input volume registers can be updated together through a linked-write flag. The serial lines are oversampled by the system clock through synchronizers, so the serial clock must be several system clocks slow.

Top module: `ccp_ctrl_port`

## Requirements
- R1: After reset, register k (on `cfg_flat[9k+8:9k]`) holds these defaults:
  - registers 0 and 1: 0x097
  - registers 2 and 3: 0x079
  - register 4: 0x01A
  - register 5: 0x008
  - register 6: 0x007
  - register 7: 0x001
  - register 8: 0x020
  - register 9: 0x000
- R2: In three-wire mode, data bits are sampled MSB first on each serial-clock rise while chip select is low. The word is committed when chip select rises: bits 15:9 are the address and bits 8:0 are the data. If more than 16 bits were clocked, the last 16 count.
- R3: A three-wire frame with fewer than 16 clocked bits changes no register.
- R4: In two-wire mode, the following is committed as one write:
  - a start condition (data falls while clock is high);
  - an address byte equal to {DEV_ADDR=0x1A, write bit 0}, sent MSB first;
  - two data bytes, first {addr[6:0], data[8]} and then data[7:0].
  The block pulls the data line low during the ninth clock of each of these three bytes.
- R5: A two-wire address byte carrying a different device address or a read bit (1) is not acknowledged. None of the bytes that follow it is acknowledged, and no register changes.
- R6: A stop condition (data rises while clock is high) ends a two-wire transfer. A transfer stopped before its second data byte completes changes no register.
- R7: A write to address 0 or 1 with data bit 8 set writes the same 9-bit value into both registers 0 and 1. With bit 8 clear, only the addressed register changes.
- R8: Writing all zeros to address 15 returns every register to its R1 default. A nonzero value written to address 15 changes nothing.
- R9: A write to an address that is not 0 to 9 and not 15 changes no register. In two-wire mode such a write is still acknowledged.
- R10: In three-wire mode, two-wire sequences cause no acknowledge and no write. In two-wire mode, chip-select frames cause no write.
- R11: The data-line pull is only ever asserted in two-wire mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| two_wire_mode | input | 1 | Protocol strap: 1 selects two-wire, 0 selects three-wire |
| ctl_cs | input | 1 | Three-wire chip select, active low |
| ctl_clk | input | 1 | Serial clock shared by both protocols |
| ctl_dat | input | 1 | Serial data line as seen at the pin |
| ctl_dat_pull | output | 1 | When 1, the pad drives the data line low (acknowledge) |
| cfg_flat | output | NUM_REGS*9 | All configuration registers; register k at bits 9k+8:9k |

## Verification
The hardest case to reach from the ports is a two-wire transfer that is cut off partway. The receiver has already acknowledged the address and the first data byte, so it holds half a command when the stop arrives. The bench builds exactly that: a full address byte and one data byte, then a stop. It confirms that the register bank keeps its old contents. A later complete transfer is then still accepted. The linked-volume path is reached from both protocols, with the flag set and with it clear, so that the partner register is seen both to follow and to hold.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 9;
  localparam int WORD_W     = ADDR_W + DATA_W;
  localparam int LINK_A     = 0;
  localparam int LINK_B     = 1;
  localparam int RESET_ADDR = 15;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      0, 1:    return 9'h097;
      2, 3:    return 9'h079;
      4:       return 9'h01A;
      5:       return 9'h008;
      6:       return 9'h007;
      7:       return 9'h001;
      8:       return 9'h020;
      default: return 9'h000;
    endcase
  endfunction
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '1;
      else     sr <= {sr[STAGES-2:0], d[i]};
    end
    assign q[i] = sr[STAGES-1];
  end
endmodule

// File: rtl/ccp_spi_rx.sv
module ccp_spi_rx
  import ccp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cs,
  input  logic sclk,
  input  logic sdat,
  output logic cmd_valid,
  output cmd_t cmd
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              prev_cs, prev_clk;
  logic [WORD_W-1:0] shift;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cs   <= 1'b1;
      prev_clk  <= 1'b1;
      shift     <= '0;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      prev_cs   <= cs;
      prev_clk  <= sclk;
      cmd_valid <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (prev_cs && !cs) begin
        cnt <= '0;
      end else if (!prev_cs && cs) begin
        if (cnt == CW'(WORD_W)) begin
          cmd_valid <= 1'b1;
          cmd       <= cmd_t'(shift);
        end
        cnt <= '0;
      end else if (!cs && !prev_clk && sclk) begin
        shift <= {shift[WORD_W-2:0], sdat};
        if (cnt != CW'(WORD_W)) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccp_twi_rx.sv
module ccp_twi_rx
  import ccp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl,
  input  logic sda,
  output logic cmd_valid,
  output cmd_t cmd,
  output logic pull
);
  typedef enum logic [1:0] {T_IDLE, T_RECV, T_ACK} tstate_t;

  tstate_t    st;
  logic       prev_scl, prev_sda;
  logic [7:0] sh, hi;
  logic [3:0] bitc;
  logic [1:0] bidx;

  logic start_c, stop_c, scl_rise, scl_fall;
  assign start_c  = en && prev_scl && scl && prev_sda && !sda;
  assign stop_c   = en && prev_scl && scl && !prev_sda && sda;
  assign scl_rise = !prev_scl && scl;
  assign scl_fall = prev_scl && !scl;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      prev_scl  <= 1'b1;
      prev_sda  <= 1'b1;
      sh        <= '0;
      hi        <= '0;
      bitc      <= '0;
      bidx      <= '0;
      pull      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      prev_scl  <= scl;
      prev_sda  <= sda;
      cmd_valid <= 1'b0;
      if (!en) begin
        st   <= T_IDLE;
        pull <= 1'b0;
      end else if (start_c) begin
        st   <= T_RECV;
        bitc <= '0;
        bidx <= '0;
        pull <= 1'b0;
      end else if (stop_c) begin
        st   <= T_IDLE;
        pull <= 1'b0;
      end else begin
        case (st)
          T_RECV: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda};
              bitc <= bitc + 1'b1;
            end else if (scl_fall && bitc == 4'd8) begin
              st   <= T_ACK;
              pull <= 1'b1;
              if (bidx == 2'd0 && sh != {DEV_ADDR, 1'b0}) begin
                st   <= T_IDLE;
                pull <= 1'b0;
              end
              if (bidx == 2'd1) hi <= sh;
              if (bidx == 2'd2) begin
                cmd_valid <= 1'b1;
                cmd       <= cmd_t'({hi, sh});
              end
            end
          end
          T_ACK: begin
            if (scl_fall) begin
              pull <= 1'b0;
              bitc <= '0;
              if (bidx == 2'd2) st <= T_IDLE;
              else begin
                bidx <= bidx + 1'b1;
                st   <= T_RECV;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ccp_regbank.sv
module ccp_regbank
  import ccp_pkg::*;
#(
  parameter int NUM_REGS = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
  localparam int IW = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              mapped, clear, linked;
  logic [IW-1:0]     idx, partner;

  assign mapped  = wr_addr < ADDR_W'(NUM_REGS);
  assign clear   = (wr_addr == ADDR_W'(RESET_ADDR)) && (wr_data == '0);
  assign linked  = wr_data[DATA_W-1] &&
                   (wr_addr == ADDR_W'(LINK_A) || wr_addr == ADDR_W'(LINK_B));
  assign idx     = wr_addr[IW-1:0];
  assign partner = (wr_addr == ADDR_W'(LINK_A)) ? IW'(LINK_B) : IW'(LINK_A);

  always_ff @(posedge clk) begin
    if (rst || (wr_valid && clear)) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else if (wr_valid && mapped) begin
      regs[idx] <= wr_data;
      if (linked) regs[partner] <= wr_data;
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_out
    assign cfg_flat[k*DATA_W +: DATA_W] = regs[k];
  end
endmodule

// File: rtl/ccp_ctrl_port.sv
module ccp_ctrl_port
  import ccp_pkg::*;
#(
  parameter int         NUM_REGS    = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h1A
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       two_wire_mode,
  input  logic                       ctl_cs,
  input  logic                       ctl_clk,
  input  logic                       ctl_dat,
  output logic                       ctl_dat_pull,
  output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
  logic [2:0]        pins_s;
  logic              spi_v, twi_v, twi_pull, wr_valid;
  cmd_t              spi_cmd, twi_cmd, wr_cmd;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  ccp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ctl_cs, ctl_clk, ctl_dat}),
    .q(pins_s)
  );

  ccp_spi_rx u_spi (
    .clk(clk), .rst(rst), .en(!two_wire_mode),
    .cs(pins_s[2]), .sclk(pins_s[1]), .sdat(pins_s[0]),
    .cmd_valid(spi_v), .cmd(spi_cmd)
  );

  ccp_twi_rx #(.DEV_ADDR(DEV_ADDR)) u_twi (
    .clk(clk), .rst(rst), .en(two_wire_mode),
    .scl(pins_s[1]), .sda(pins_s[0]),
    .cmd_valid(twi_v), .cmd(twi_cmd), .pull(twi_pull)
  );

  assign wr_valid     = spi_v || twi_v;
  assign wr_cmd       = twi_v ? twi_cmd : spi_cmd;
  assign wr_addr      = wr_cmd.addr;
  assign wr_data      = wr_cmd.data;
  assign ctl_dat_pull = twi_pull;

  ccp_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_flat(cfg_flat)
  );
endmodule

// File: rtl/ccp_ctrl_port_chk.sv
module ccp_ctrl_port_chk #(
  parameter int NUM_REGS = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  two_wire_mode,
  input logic                  ctl_dat_pull,
  input logic [NUM_REGS*9-1:0] cfg_flat,
  input logic                  wr_valid,
  input logic [6:0]            wr_addr,
  input logic [8:0]            wr_data
);
  logic [NUM_REGS*9-1:0] def_flat;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) def_flat[i*9 +: 9] = ccp_pkg::reg_default(i);
  end

  assert_pull_mode_R11: assert property (@(posedge clk) disable iff (rst)
    ctl_dat_pull |-> two_wire_mode);

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cfg_flat == def_flat);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 7'd15 && wr_data == 9'd0) |=> cfg_flat == def_flat);

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr >= 7'(NUM_REGS) && wr_addr != 7'd15) |=> $stable(cfg_flat));

  assert_linked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == 7'd0 && wr_data[8]) |=>
      (cfg_flat[8:0] == $past(wr_data) && cfg_flat[17:9] == $past(wr_data)));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(cfg_flat));
endmodule

bind ccp_ctrl_port ccp_ctrl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .two_wire_mode(two_wire_mode),
  .ctl_dat_pull(ctl_dat_pull), .cfg_flat(cfg_flat),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/ccp_ctrl_port_tb.sv
module ccp_ctrl_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 10;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic two_wire_mode = 1'b0;
  logic ctl_cs = 1'b1, ctl_clk = 1'b0, ctl_dat = 1'b1;
  logic ctl_dat_pull;
  logic [NR*9-1:0] cfg_flat;

  int n_cmp = 0, n_bad = 0;
  bit busy = 1'b1;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [8:0] exp_r [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccp_ctrl_port u_dut (
    .clk(clk), .rst(rst), .two_wire_mode(two_wire_mode),
    .ctl_cs(ctl_cs), .ctl_clk(ctl_clk), .ctl_dat(ctl_dat),
    .ctl_dat_pull(ctl_dat_pull), .cfg_flat(cfg_flat)
  );

  function automatic logic [8:0] dflt(input int i);
    case (i)
      0, 1: return 9'h097;
      2, 3: return 9'h079;
      4: return 9'h01A;
      5: return 9'h008;
      6: return 9'h007;
      7: return 9'h001;
      8: return 9'h020;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [NR*9-1:0] exp_flat();
    logic [NR*9-1:0] v;
    for (int i = 0; i < NR; i++) v[i*9 +: 9] = exp_r[i];
    return v;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Reference model of the bank (R1, R7, R8, R9)
  task automatic model_write(input int a, input logic [8:0] d);
    if (a == 15 && d == 9'd0) begin
      for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
    end else if (a < NR) begin
      exp_r[a] = d;
      if (d[8] && (a == 0 || a == 1)) exp_r[a ^ 1] = d;
    end
  endtask

  // Per-clock comparison while the bus is idle
  always @(negedge clk) begin
    if (!rst && !busy && !done) begin
      n_cmp++;
      if (cfg_flat !== exp_flat()) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", cur_req, cfg_flat, exp_flat());
      end
    end
  end

  task automatic spi_frame(input logic [19:0] bits, input int n);
    busy = 1'b1;
    ctl_clk = 1'b0; wait_clk(H);
    ctl_cs = 1'b0;  wait_clk(H);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_dat = bits[i]; wait_clk(H);
      ctl_clk = 1'b1;    wait_clk(H);
      ctl_clk = 1'b0;
    end
    wait_clk(H);
    ctl_cs = 1'b1;
    wait_clk(12);
  endtask

  task automatic spi_write(input int a, input logic [8:0] d, input bit takes, input string req);
    cur_req = req;
    spi_frame({4'h0, 7'(a), d}, 16);
    if (takes) model_write(a, d);
    busy = 1'b0;
    wait_clk(4);
  endtask

  task automatic twi_start();
    ctl_dat = 1'b1; ctl_clk = 1'b1; wait_clk(H);
    ctl_dat = 1'b0; wait_clk(H);
    ctl_clk = 1'b0; wait_clk(H);
  endtask

  task automatic twi_stop();
    ctl_dat = 1'b0; wait_clk(H);
    ctl_clk = 1'b1; wait_clk(H);
    ctl_dat = 1'b1; wait_clk(H);
  endtask

  task automatic twi_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic line;
    for (int i = 7; i >= 0; i--) begin
      ctl_dat = b[i]; wait_clk(H);
      ctl_clk = 1'b1; wait_clk(H);
      ctl_clk = 1'b0; wait_clk(H);
    end
    ctl_dat = 1'b1; wait_clk(H);
    ctl_clk = 1'b1; wait_clk(H/2);
    line = ctl_dat & ~ctl_dat_pull;
    check(line == !exp_ack, req, 32'(line), 32'(!exp_ack));
    wait_clk(H/2);
    ctl_clk = 1'b0; wait_clk(H);
  endtask

  // ndata: number of data bytes sent before the stop
  task automatic twi_write(input logic [7:0] devb, input int a, input logic [8:0] d,
                           input int ndata, input bit takes, input string req);
    bit hit;
    hit = two_wire_mode && (devb == 8'h34);
    cur_req = req;
    busy = 1'b1;
    twi_start();
    twi_byte(devb, hit, req);
    twi_byte({7'(a), d[8]}, hit, req);
    if (ndata > 1) twi_byte(d[7:0], hit, req);
    twi_stop();
    wait_clk(12);
    if (takes) model_write(a, d);
    busy = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check(cfg_flat == exp_flat(), "R1", 32'(cfg_flat[8:0]), 32'(dflt(0)));
    check(cfg_flat[5*9 +: 9] == 9'h008, "R1", 32'(cfg_flat[5*9 +: 9]), 32'h008);
    busy = 1'b0;
    wait_clk(4);

    // Three-wire mode
    spi_write(2, 9'h155, 1, "R2");
    spi_write(5, 9'h006, 1, "R2");
    cur_req = "R2";
    spi_frame({4'hA, 7'd4, 9'h0F3}, 20);
    model_write(4, 9'h0F3); busy = 1'b0; wait_clk(4);
    cur_req = "R3";
    spi_frame({10'h0, 10'h2AB}, 10);
    busy = 1'b0; wait_clk(4);
    spi_write(0, 9'h11F, 1, "R7");
    check(cfg_flat[17:9] == 9'h11F, "R7", 32'(cfg_flat[17:9]), 32'h11F);
    spi_write(1, 9'h085, 1, "R7");
    check(cfg_flat[8:0] == 9'h11F, "R7", 32'(cfg_flat[8:0]), 32'h11F);
    spi_write(12, 9'h1FF, 0, "R9");
    spi_write(15, 9'h001, 0, "R8");
    spi_write(15, 9'h000, 1, "R8");
    check(cfg_flat[2*9 +: 9] == 9'h079, "R8", 32'(cfg_flat[2*9 +: 9]), 32'h079);
    twi_write(8'h34, 6, 9'h0AA, 2, 0, "R10");

    // Two-wire mode
    ctl_clk = 1'b1; ctl_dat = 1'b1; wait_clk(4);
    two_wire_mode = 1'b1; wait_clk(8);
    twi_write(8'h34, 3, 9'h0AA, 2, 1, "R4");
    twi_write(8'h34, 1, 9'h1F0, 2, 1, "R7");
    check(cfg_flat[8:0] == 9'h1F0, "R7", 32'(cfg_flat[8:0]), 32'h1F0);
    twi_write(8'h36, 7, 9'h0FF, 2, 0, "R5");
    twi_write(8'h35, 7, 9'h0FF, 2, 0, "R5");
    twi_write(8'h34, 8, 9'h111, 1, 0, "R6");
    twi_write(8'h34, 8, 9'h112, 2, 1, "R6");
    twi_write(8'h34, 100, 9'h1AB, 2, 0, "R9");
    cur_req = "R10";
    spi_frame({4'h0, 7'd2, 9'h033}, 16);
    busy = 1'b0; wait_clk(4);
    ctl_clk = 1'b1; ctl_dat = 1'b1; wait_clk(4);
    check(ctl_dat_pull == 1'b0, "R11", 32'(ctl_dat_pull), 32'h0);
    twi_write(8'h34, 15, 9'h000, 2, 1, "R8");
    check(cfg_flat == exp_flat(), "R8", 32'(cfg_flat[8:0]), 32'(dflt(0)));

    wait_clk(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule